// File: doc/BRIEF.md
# DS3 C-bit Parity M-frame Transmit Framer

This block produces the serial line bit stream of a DS3 M-frame in C-bit parity format, one bit per clock. Payload bits are pulled from an upstream source through a ready/valid handshake. The block inserts every overhead bit in its fixed slot: the subframe lead bits (X, P, multiframe M), the framing bits F and the control C bits. The parity of each frame's information bits is carried in both the P bits and the control-parity C bits of the following frame. The far-end block error bits and the X bits report status from the local receive side. The far-end alarm channel and data link bits come from input pins.

A frame is 4760 bits long. It holds 7 subframes of 8 blocks, and each block is 85 bits: one overhead bit followed by 84 payload bits. Back-pressure goes upstream only. `pay_ready` is high exactly in payload slots and its timing is fixed by the frame position, not by `pay_valid`. A bit is consumed when `pay_ready` and `pay_valid` are both high. If `pay_valid` is low in a payload slot, nothing is consumed and the slot carries a 1. The line side has no back-pressure.

Top module: `ds3_cbit_framer`

## Requirements
- R1: The line repeats a 4760-bit frame made of 7 subframes × 8 blocks × 85 bits. `frame_start` is high in the cycle `line_bit` carries the first bit of a frame. Bit 0 of every block is overhead and bits 1..84 are payload, sent in the order accepted.
- R2: In every subframe the overhead bits of blocks 2, 4, 6 and 8 (1-based) are 1, 0, 0, 1. The block-1 overhead bit of subframes 5, 6 and 7 is 0, 1, 0.
- R3: `pay_ready` is high only in payload slots. An accepted `pay_data` bit appears on `line_bit` one cycle later. A payload slot with `pay_valid` low sends 1.
- R4: The X bits (block-1 overhead of subframes 1 and 2) are equal within a frame. They are 1 normally. They are 0 in every frame whose final bit before it falls within OOF_HOLD cycles after an `oof_in` pulse.
- R5: The P bits (block-1 overhead of subframes 3 and 4) of frame n+1 both equal the XOR of all 4704 payload bits sent in frame n. In the first frame after reset they are 1.
- R6: The three C bits of subframe 3 (overhead of blocks 3, 5 and 7) equal that frame's P value.
- R7: The three C bits of subframe 4 are 0 if `rx_par_err` was high in any cycle after the previous end of subframe 3, up to and including this frame's end of subframe 3. Otherwise they are 1.
- R8: In subframe 1, the first and second C bits are 1 and the third C bit carries `feac_bit`.
- R9: The C bits of subframes 2, 5, 6 and 7 carry `dl_bit`. `dl_take` is high in each such slot cycle, and the value on `dl_bit` in that cycle is sent one cycle later.
- R10: During reset, `line_bit`, `frame_start`, `pay_ready` and `dl_take` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_valid | input | 1 | Upstream has a payload bit |
| pay_data | input | 1 | Payload bit |
| pay_ready | output | 1 | Current slot takes a payload bit |
| feac_bit | input | 1 | Far-end alarm channel bit |
| dl_bit | input | 1 | Data link bit |
| dl_take | output | 1 | Current slot takes `dl_bit` |
| rx_par_err | input | 1 | Receive side saw a parity error |
| oof_in | input | 1 | Pulse: receive side went out of frame |
| line_bit | output | 1 | Serial DS3 output bit |
| frame_start | output | 1 | Marks the first bit of a frame on `line_bit` |

## Verification
Every slot decision is registered once, so a payload or data link bit shows up on `line_bit` one cycle after its handshake cycle. The X value is fixed on the final bit of the frame before, the error flag is captured on the last bit of subframe 3, and the parity is latched on the last payload bit of a frame. The bench samples at the falling edge and indexes every line bit by its offset from `frame_start`, so each field is judged at its frame position and no cycle count is guessed. The status pulses are placed a fixed number of cycles after a frame start. The bench then checks the whole frame that contains the pulse and the frames after it, because each result lands in a known frame rather than at a fixed delay.

// File: rtl/ds3_cbit_pkg.sv
package ds3_cbit_pkg;
  // Kind of slot at the current frame position
  typedef enum logic [1:0] {
    SLOT_PAY   = 2'd0,
    SLOT_LEAD  = 2'd1,
    SLOT_FRAME = 2'd2,
    SLOT_CTRL  = 2'd3
  } slot_e;
endpackage

// File: rtl/ds3_mframe_pos.sv
module ds3_mframe_pos #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  localparam int SFW = $clog2(SUBFRAMES),
  localparam int BKW = $clog2(BLOCKS),
  localparam int BTW = $clog2(BLOCK_BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [SFW-1:0] sf,
  output logic [BKW-1:0] blk,
  output logic [BTW-1:0] bitn,
  output logic           oh_slot,
  output logic           sf_end,
  output logic           frame_first,
  output logic           frame_last
);
  localparam logic [SFW-1:0] SF_MAX  = SFW'(SUBFRAMES - 1);
  localparam logic [BKW-1:0] BLK_MAX = BKW'(BLOCKS - 1);
  localparam logic [BTW-1:0] BIT_MAX = BTW'(BLOCK_BITS - 1);

  logic blk_end;

  assign blk_end     = (bitn == BIT_MAX);
  assign sf_end      = blk_end && (blk == BLK_MAX);
  assign frame_last  = sf_end && (sf == SF_MAX);
  assign frame_first = (sf == '0) && (blk == '0) && (bitn == '0);
  assign oh_slot     = (bitn == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf   <= '0;
      blk  <= '0;
      bitn <= '0;
    end else if (blk_end) begin
      bitn <= '0;
      if (blk == BLK_MAX) begin
        blk <= '0;
        sf  <= (sf == SF_MAX) ? '0 : sf + 1'b1;
      end else begin
        blk <= blk + 1'b1;
      end
    end else begin
      bitn <= bitn + 1'b1;
    end
  end

  // R1: the last position of a frame is followed by the first
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> frame_first);
  // R1: position bits never leave their legal ranges
  p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sf <= SF_MAX) && (blk <= BLK_MAX) && (bitn <= BIT_MAX));
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sent_bit,
  input  logic frame_last,
  output logic par_bit
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      par_bit <= 1'b1;
    end else if (frame_last) begin
      par_bit <= acc_q ^ (take & sent_bit);
      acc_q   <= 1'b0;
    end else if (take) begin
      acc_q <= acc_q ^ sent_bit;
    end
  end

  // R5: the carried parity only moves at a frame boundary
  p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(par_bit));
endmodule

// File: rtl/ds3_far_status.sv
module ds3_far_status #(
  parameter int OOF_HOLD = 44736000,
  localparam int HW = $clog2(OOF_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_last,
  input  logic febe_cap,
  input  logic oof_in,
  input  logic rx_par_err,
  output logic x_bit,
  output logic febe_bit
);
  logic [HW-1:0] hold_q;
  logic          err_pend_q;

  // Out-of-frame hold window
  always_ff @(posedge clk) begin
    if (!rst_n)              hold_q <= '0;
    else if (oof_in)         hold_q <= HW'(OOF_HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  // X value for the next frame is fixed on the last bit of this one
  always_ff @(posedge clk) begin
    if (!rst_n)          x_bit <= 1'b1;
    else if (frame_last) x_bit <= !(oof_in || (hold_q != '0));
  end

  // Error flag gathered between captures
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pend_q <= 1'b0;
      febe_bit   <= 1'b1;
    end else if (febe_cap) begin
      febe_bit   <= !(err_pend_q || rx_par_err);
      err_pend_q <= 1'b0;
    end else begin
      err_pend_q <= err_pend_q || rx_par_err;
    end
  end

  // R4: X value never changes inside a frame
  p_x_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(x_bit));
  // R4: a fresh out-of-frame report opens the hold window
  p_hold_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oof_in |=> (hold_q != '0));
  // R7: error status only moves at its capture point
  p_febe_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !febe_cap |=> $stable(febe_bit));
endmodule

// File: rtl/ds3_cbit_framer.sv
module ds3_cbit_framer #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter int OOF_HOLD   = 44736000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pay_valid,
  input  logic pay_data,
  output logic pay_ready,
  input  logic feac_bit,
  input  logic dl_bit,
  output logic dl_take,
  input  logic rx_par_err,
  input  logic oof_in,
  output logic line_bit,
  output logic frame_start
);
  import ds3_cbit_pkg::*;

  localparam int SFW = $clog2(SUBFRAMES);
  localparam int BKW = $clog2(BLOCKS);
  localparam int BTW = $clog2(BLOCK_BITS);

  logic [SFW-1:0] pos_sf;
  logic [BKW-1:0] pos_blk;
  logic [BTW-1:0] pos_bit;
  logic           pos_oh, pos_sf_end, pos_first, pos_last;
  logic           par_bit, x_bit, febe_bit, febe_cap;
  logic           nxt_bit;
  slot_e          slot;

  ds3_mframe_pos #(
    .SUBFRAMES (SUBFRAMES),
    .BLOCKS    (BLOCKS),
    .BLOCK_BITS(BLOCK_BITS)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf         (pos_sf),
    .blk        (pos_blk),
    .bitn       (pos_bit),
    .oh_slot    (pos_oh),
    .sf_end     (pos_sf_end),
    .frame_first(pos_first),
    .frame_last (pos_last)
  );

  // Error status is captured on the last bit of the third subframe
  assign febe_cap = pos_sf_end && (int'(pos_sf) == 2);

  ds3_far_status #(.OOF_HOLD(OOF_HOLD)) u_far (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_last(pos_last),
    .febe_cap  (febe_cap),
    .oof_in    (oof_in),
    .rx_par_err(rx_par_err),
    .x_bit     (x_bit),
    .febe_bit  (febe_bit)
  );

  ds3_parity_acc u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (pay_ready),
    .sent_bit  (nxt_bit),
    .frame_last(pos_last),
    .par_bit   (par_bit)
  );

  // Slot classification
  always_comb begin
    if (!pos_oh) begin
      slot = SLOT_PAY;
    end else begin
      case (int'(pos_blk))
        0:       slot = SLOT_LEAD;
        2, 4, 6: slot = SLOT_CTRL;
        default: slot = SLOT_FRAME;
      endcase
    end
  end

  // Bit selection for the current slot
  always_comb begin
    nxt_bit   = 1'b1;
    pay_ready = 1'b0;
    dl_take   = 1'b0;
    case (slot)
      SLOT_PAY: begin
        pay_ready = 1'b1;
        nxt_bit   = pay_valid ? pay_data : 1'b1;
      end
      SLOT_LEAD: begin
        case (int'(pos_sf))
          0, 1:    nxt_bit = x_bit;
          2, 3:    nxt_bit = par_bit;
          5:       nxt_bit = 1'b1;
          default: nxt_bit = 1'b0;
        endcase
      end
      SLOT_FRAME: begin
        nxt_bit = (int'(pos_blk) == 1) || (int'(pos_blk) == 7);
      end
      SLOT_CTRL: begin
        case (int'(pos_sf))
          0:       nxt_bit = (int'(pos_blk) == 6) ? feac_bit : 1'b1;
          2:       nxt_bit = par_bit;
          3:       nxt_bit = febe_bit;
          default: begin
            nxt_bit = dl_bit;
            dl_take = 1'b1;
          end
        endcase
      end
      default: nxt_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_bit    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      line_bit    <= nxt_bit;
      frame_start <= pos_first;
    end
  end

  // R2: second block overhead of any subframe is sent as 1
  p_f1_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_oh && int'(pos_blk) == 1) |=> line_bit);
  // R2: fourth block overhead of any subframe is sent as 0
  p_f0_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_oh && int'(pos_blk) == 3) |=> !line_bit);
  // R2: multiframe lead bit of the sixth subframe is 1
  p_m1_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_oh && int'(pos_blk) == 0 && int'(pos_sf) == 5) |=> line_bit);
  // R3: an accepted payload bit is the next line bit
  p_pay_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && pay_valid) |=> (line_bit == $past(pay_data)));
  // R3: no payload is requested in an overhead slot
  p_no_req_oh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_oh |-> !pay_ready);
  // R9: a taken data link bit is the next line bit
  p_dl_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dl_take |=> (line_bit == $past(dl_bit)));
  // R1: the frame marker follows the first frame position
  p_sof_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pos_first |=> frame_start);
endmodule

// File: tb/ds3_cbit_framer_tb.sv
module ds3_cbit_framer_tb;
  localparam int FRAME = 4760;
  localparam int BB    = 85;
  localparam int SFB   = 680;
  localparam int HOLD  = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pay_valid = 1'b0, pay_data = 1'b0, feac_bit = 1'b0, dl_bit = 1'b0;
  logic rx_par_err = 1'b0, oof_in = 1'b0;
  logic pay_ready, dl_take, line_bit, frame_start;

  always #10 clk = ~clk;

  ds3_cbit_framer #(.OOF_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
    .feac_bit(feac_bit), .dl_bit(dl_bit), .dl_take(dl_take),
    .rx_par_err(rx_par_err), .oof_in(oof_in),
    .line_bit(line_bit), .frame_start(frame_start)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit payq[$];
  bit dlq[$];
  bit cur[FRAME];
  bit lastf[FRAME];
  int idx = -1;
  bit pay_bad = 0, dl_bad = 0, len_bad = 0, expect_sof = 0;
  bit l_pay_bad = 0, l_dl_bad = 0;
  bit par_run = 0, exp_p_cur = 1, l_exp_p = 1;
  int frames_done = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit gap_mode = 0, fill_mode = 0;
  int dl_k = 0;

  // Recorder and stimulus driver, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int b, bk, sf;
      bit e;
      if (expect_sof && !frame_start) len_bad = 1;
      expect_sof = 0;
      if (frame_start) begin
        if (idx != -1) len_bad = 1;
        idx = 0;
      end
      if (idx >= 0) begin
        b  = idx % BB;
        bk = (idx / BB) % 8;
        sf = idx / SFB;
        cur[idx] = line_bit;
        if (b != 0) begin
          if (payq.size() == 0) pay_bad = 1;
          else begin
            e = payq.pop_front();
            if (e !== line_bit) pay_bad = 1;
          end
          par_run ^= line_bit;
        end else if ((bk == 2 || bk == 4 || bk == 6) &&
                     (sf == 1 || sf == 4 || sf == 5 || sf == 6)) begin
          if (dlq.size() == 0) dl_bad = 1;
          else begin
            e = dlq.pop_front();
            if (e !== line_bit) dl_bad = 1;
          end
        end
        idx++;
        if (idx == FRAME) begin
          lastf     = cur;
          l_pay_bad = pay_bad;
          l_dl_bad  = dl_bad;
          l_exp_p   = exp_p_cur;
          exp_p_cur = par_run;
          par_run   = 0;
          pay_bad   = 0;
          dl_bad    = 0;
          idx       = -1;
          expect_sof = 1;
          frames_done++;
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pay_data  = lfsr[0];
      pay_valid = fill_mode ? 1'b0 : (gap_mode ? (lfsr[3] | lfsr[7]) : 1'b1);
      if (pay_ready) payq.push_back(pay_valid ? pay_data : 1'b1);
      dl_bit = dl_k[0] ^ dl_k[2];
      if (dl_take) begin
        dlq.push_back(dl_bit);
        dl_k++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_frame();
    int n;
    n = frames_done;
    while (frames_done == n) @(negedge clk);
  endtask

  task automatic wait_sof();
    do @(negedge clk); while (!frame_start);
  endtask

  // Checks every field of the last completed frame
  task automatic check_frame(input string name, input bit ex_x,
                             input bit ex_fe, input bit ex_feac);
    bit fok;
    fok = 1;
    for (int s = 0; s < 7; s++) begin
      if (lastf[s*SFB + 85] != 1 || lastf[s*SFB + 255] != 0 ||
          lastf[s*SFB + 425] != 0 || lastf[s*SFB + 595] != 1) fok = 0;
    end
    chk(fok, "R2", {name, " framing bits"}, fok, 1);
    chk(lastf[4*SFB] == 0 && lastf[5*SFB] == 1 && lastf[6*SFB] == 0, "R2",
        {name, " multiframe bits"},
        {lastf[4*SFB], lastf[5*SFB], lastf[6*SFB]}, 3'b010);
    chk(lastf[0] == ex_x && lastf[SFB] == ex_x, "R4", {name, " X pair"},
        {lastf[0], lastf[SFB]}, {ex_x, ex_x});
    chk(lastf[2*SFB] == l_exp_p && lastf[3*SFB] == l_exp_p, "R5",
        {name, " P pair"}, {lastf[2*SFB], lastf[3*SFB]}, {l_exp_p, l_exp_p});
    chk(lastf[2*SFB+170] == l_exp_p && lastf[2*SFB+340] == l_exp_p &&
        lastf[2*SFB+510] == l_exp_p, "R6", {name, " CP bits"},
        {lastf[2*SFB+170], lastf[2*SFB+340], lastf[2*SFB+510]},
        {l_exp_p, l_exp_p, l_exp_p});
    chk(lastf[3*SFB+170] == ex_fe && lastf[3*SFB+340] == ex_fe &&
        lastf[3*SFB+510] == ex_fe, "R7", {name, " FEBE bits"},
        {lastf[3*SFB+170], lastf[3*SFB+340], lastf[3*SFB+510]},
        {ex_fe, ex_fe, ex_fe});
    chk(lastf[170] == 1 && lastf[340] == 1, "R8", {name, " C1 C2"},
        {lastf[170], lastf[340]}, 2'b11);
    chk(lastf[510] == ex_feac, "R8", {name, " C3 alarm bit"},
        lastf[510], ex_feac);
    chk(!l_pay_bad, "R3", {name, " payload order and fill"}, l_pay_bad, 0);
    chk(!l_dl_bad, "R9", {name, " data link bits"}, l_dl_bad, 0);
    chk(!len_bad, "R1", {name, " frame length"}, len_bad, 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(line_bit == 0 && frame_start == 0 && pay_ready == 0 && dl_take == 0,
        "R10", "reset outputs",
        {line_bit, frame_start, pay_ready, dl_take}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first();
    wait_frame();
    check_frame("first", 1, 1, 0);
    chk(lastf[2*SFB] == 1, "R5", "boot P value", lastf[2*SFB], 1);
  endtask

  task automatic t_feac();
    feac_bit = 1'b1;
    wait_frame();
    wait_frame();
    check_frame("alarm", 1, 1, 1);
  endtask

  task automatic t_gaps();
    gap_mode = 1;
    wait_frame();
    wait_frame();
    check_frame("gaps", 1, 1, 1);
    gap_mode = 0;
  endtask

  task automatic t_fill();
    fill_mode = 1;
    wait_frame();
    wait_frame();
    check_frame("fill", 1, 1, 1);
    fill_mode = 0;
    wait_frame();
    check_frame("after fill", 1, 1, 1);
    chk(lastf[2*SFB] == 0, "R5", "P after all-ones payload", lastf[2*SFB], 0);
  endtask

  task automatic t_febe();
    wait_sof();
    repeat (50) @(negedge clk);
    rx_par_err = 1'b1;
    @(negedge clk);
    rx_par_err = 1'b0;
    wait_frame();
    check_frame("error frame", 1, 0, 1);
    wait_frame();
    check_frame("error cleared", 1, 1, 1);
  endtask

  task automatic t_oof();
    wait_sof();
    repeat (50) @(negedge clk);
    oof_in = 1'b1;
    @(negedge clk);
    oof_in = 1'b0;
    wait_frame();
    check_frame("oof frame", 1, 1, 1);
    wait_frame();
    check_frame("oof held", 0, 1, 1);
    wait_frame();
    check_frame("oof released", 1, 1, 1);
  endtask

  initial begin
    t_reset();
    t_first();
    t_feac();
    t_gaps();
    t_fill();
    t_febe();
    t_oof();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", frames_done, 15);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule